// File: doc/BRIEF.md
# Packed Lane Adder with Compare Flags

This block adds or subtracts two 32-bit words as independent lanes: four 8-bit lanes or two 16-bit lanes, each treated as signed or unsigned. The lane results form the 32-bit result combinationally. Each lane also computes a greater-or-equal flag. A four-bit flag register captures these flags on the clock edge when the caller asks for it.

A separate select operation uses the stored flags to build a result byte by byte from the two operands. A typical sequence is a compare (subtract with the flag write enabled) followed by a select. Together they give a per-lane max, min or merge without branches.

The opcode is four bits, ordered {select, halfword, signed, subtract}. Any opcode with bit 3 set is a select. Otherwise bit 2 picks 16-bit lanes, bit 1 picks signed arithmetic and bit 0 picks subtraction.

Top module: `packed_lane_alu`

## Requirements
- R1: With opcode bit 2 clear and bit 3 clear, result bits [8i+7:8i] equal op_a byte i plus or minus op_b byte i, taken modulo 256. No carry or borrow crosses between bytes.
- R2: With opcode bit 2 set and bit 3 clear, each 16-bit half of the result is the matching operand halves added or subtracted modulo 65536, independently of the other half.
- R3: For unsigned addition (bit 1 clear, bit 0 clear), a lane's flag is 1 exactly when the true sum is 2^W or more, where W is the lane width.
- R4: For unsigned subtraction (bit 1 clear, bit 0 set), a lane's flag is 1 exactly when op_a's lane is at least op_b's lane, so that no borrow occurs.
- R5: For signed addition or subtraction (bit 1 set), a lane's flag is 1 exactly when the full-precision result is zero or positive.
- R6: In byte mode, ge_flags[i] comes from byte lane i. Byte lane i is result bits [8i+7:8i], so ge_flags[3] comes from the top byte.
- R7: In halfword mode, ge_flags[3] and ge_flags[2] both take the flag of the upper half. ge_flags[1] and ge_flags[0] both take the flag of the lower half.
- R8: With opcode bit 3 set, result byte i equals op_a byte i when stored flag i is 1, and op_b byte i otherwise.
- R9: The flag register loads on a rising clock edge only when flag_we is 1 and opcode bit 3 is 0. In every other cycle it holds its value, including select cycles with flag_we set.
- R10: While rst_n is low, ge_flags reads 0. Reset takes effect asynchronously and is released on a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 4 | {select, halfword, signed, subtract} |
| flag_we | input | 1 | Load the lane flags at the next edge (arithmetic opcodes only) |
| result | output | 32 | Lane results, or the byte-selected word |
| ge_flags | output | 4 | Stored greater-or-equal flags |

## Verification
The hardest cases to reach are the lane-boundary results. Examples are a signed sum of exactly -2^W, a difference of exactly +2^(W-1), and an unsigned sum that wraps to zero. In these cases the wrapped lane value and the flag disagree with a naive sign or carry reading. The stimulus table places these operand pairs in single lanes next to lanes that do not overflow, so a carry that leaks between lanes shows up too.

Select is checked with flag patterns left over from earlier vectors. A select with flag_we held high then confirms that the flags do not move.

// File: rtl/pksimd_pkg.sv
package pksimd_pkg;
  // opcode field order is part of the interface: {sel, half, sgn, sub}
  typedef struct packed {
    logic sel;
    logic half;
    logic sgn;
    logic sub;
  } op_t;
endpackage

// File: rtl/pksimd_rst_sync.sv
module pksimd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pksimd_lane.sv
module pksimd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  input  logic         is_sgn,
  output logic [W-1:0] sum,
  output logic         ge
);
  logic [W:0] ea, eb, ext;

  always_comb begin
    ea  = {is_sgn & a[W-1], a};
    eb  = {is_sgn & b[W-1], b};
    ext = is_sub ? (ea - eb) : (ea + eb);
    sum = ext[W-1:0];
    // unsigned add: carry out; otherwise a clear top bit means non-negative
    ge  = (is_sgn | is_sub) ? ~ext[W] : ext[W];
  end
endmodule

// File: rtl/pksimd_flags.sv
module pksimd_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] flag_q, flag_d;

  always_comb flag_d = we ? d : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign q = flag_q;
endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         op_a,
  input  logic [DATA_W-1:0]         op_b,
  input  logic [3:0]                opcode,
  input  logic                      flag_we,
  output logic [DATA_W-1:0]         result,
  output logic [DATA_W/BYTE_W-1:0]  ge_flags
);
  import pksimd_pkg::*;

  localparam int NB     = DATA_W / BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int NH     = NB / 2;

  op_t op;
  assign op = op_t'(opcode);

  logic rst_sync_n;
  pksimd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  logic [BYTE_W-1:0] byte_sum [NB];
  logic [NB-1:0]     byte_ge;
  logic [HALF_W-1:0] half_sum [NH];
  logic [NH-1:0]     half_ge;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    pksimd_lane #(.W(BYTE_W)) u_lane (
      .a(op_a[i*BYTE_W +: BYTE_W]), .b(op_b[i*BYTE_W +: BYTE_W]),
      .is_sub(op.sub), .is_sgn(op.sgn),
      .sum(byte_sum[i]), .ge(byte_ge[i])
    );
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    pksimd_lane #(.W(HALF_W)) u_lane (
      .a(op_a[h*HALF_W +: HALF_W]), .b(op_b[h*HALF_W +: HALF_W]),
      .is_sub(op.sub), .is_sgn(op.sgn),
      .sum(half_sum[h]), .ge(half_ge[h])
    );
  end

  logic [NB-1:0] ge_new;
  logic          flag_load;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      ge_new[i] = op.half ? half_ge[i/2] : byte_ge[i];
    end
    flag_load = flag_we & ~op.sel;
  end

  pksimd_flags #(.N(NB)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .we(flag_load), .d(ge_new), .q(ge_flags)
  );

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      if (op.sel)
        result[i*BYTE_W +: BYTE_W] = ge_flags[i] ? op_a[i*BYTE_W +: BYTE_W]
                                                 : op_b[i*BYTE_W +: BYTE_W];
      else if (op.half)
        result[i*BYTE_W +: BYTE_W] = half_sum[i/2][(i%2)*BYTE_W +: BYTE_W];
      else
        result[i*BYTE_W +: BYTE_W] = byte_sum[i];
    end
  end

  // ---------------- assertions ----------------
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(flag_we && !op.sel) |=> $stable(ge_flags));

  assert_half_pairs_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_we && !op.sel && op.half) |=>
      (ge_flags[3] == ge_flags[2] && ge_flags[1] == ge_flags[0]));

  assert_sel_all_a_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op.sel && ge_flags == '1) |-> (result == op_a));

  assert_sel_all_b_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op.sel && ge_flags == '0) |-> (result == op_b));

  for (genvar i = 0; i < NB; i++) begin : g_lane_chk
    assert_uadd_carry_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!op.sgn && !op.sub) |->
        (byte_ge[i] == (byte_sum[i] < op_a[i*BYTE_W +: BYTE_W])));
    assert_usub_noborrow_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!op.sgn && op.sub) |->
        (byte_ge[i] == (op_a[i*BYTE_W +: BYTE_W] >= op_b[i*BYTE_W +: BYTE_W])));
  end

  for (genvar h = 0; h < NH; h++) begin : g_half_chk
    assert_ssub_sign_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (op.sgn && op.sub) |->
        (half_ge[h] == ($signed(op_a[h*HALF_W +: HALF_W]) >=
                        $signed(op_b[h*HALF_W +: HALF_W]))));
  end
endmodule

// File: tb/sim_packed_lane_alu.sv
module sim_packed_lane_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [3:0]  opcode;
  logic        flag_we;
  logic [31:0] result;
  logic [3:0]  ge_flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  packed_lane_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .flag_we(flag_we), .result(result), .ge_flags(ge_flags)
  );

  // {we, opcode, a, b, expected result, expected flags after the edge}
  localparam int NV = 11;
  localparam logic [104:0] VEC [NV] = '{
    {1'b1, 4'b0000, 32'h80FF0102, 32'h80010203, 32'h00000305, 4'b1100}, // R1 R3 R6
    {1'b1, 4'b0001, 32'h05000310, 32'h06000210, 32'hFF000100, 4'b0111}, // R1 R4
    {1'b1, 4'b0010, 32'h7F80FF01, 32'h0180FFFF, 32'h8000FE00, 4'b1001}, // R5
    {1'b1, 4'b0011, 32'h80007F05, 32'h0101FF05, 32'h7FFF8000, 4'b0011}, // R5
    {1'b1, 4'b0100, 32'hFFFF0001, 32'h00010002, 32'h00000003, 4'b1100}, // R2 R3 R7
    {1'b1, 4'b0101, 32'h00010100, 32'h000200FF, 32'hFFFF0001, 4'b0011}, // R2 R4 R7
    {1'b1, 4'b0110, 32'h80000001, 32'h8000FFFE, 32'h0000FFFF, 4'b0000}, // R2 R5
    {1'b1, 4'b0111, 32'h7FFF1234, 32'hFFFF1234, 32'h80000000, 4'b1111}, // R5 R7
    {1'b1, 4'b1000, 32'hAABBCCDD, 32'h11223344, 32'hAABBCCDD, 4'b1111}, // R8 R9
    {1'b1, 4'b0000, 32'h00FF00FF, 32'h00010001, 32'h00000000, 4'b0101}, // R1 R6
    {1'b1, 4'b1000, 32'hAABBCCDD, 32'h11223344, 32'h11BB33DD, 4'b0101}  // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; opcode = '0; flag_we = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R10 flags in reset", {28'd0, ge_flags}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 flags after release", {28'd0, ge_flags}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      flag_we = VEC[v][104];
      opcode  = VEC[v][103:100];
      op_a    = VEC[v][99:68];
      op_b    = VEC[v][67:36];
      #1 check($sformatf("R1 R2 R8 result vec %0d", v), result, VEC[v][35:4]);
      @(posedge clk);
      #1 check($sformatf("R3 R4 R5 R6 R7 flags vec %0d", v),
               {28'd0, ge_flags}, {28'd0, VEC[v][3:0]});
    end

    // R9: arithmetic with flag_we low leaves flags (0101) untouched
    @(negedge clk);
    flag_we = 1'b0; opcode = 4'b0000; op_a = 32'hFF00FF00; op_b = 32'h01000100;
    #1 check("R1 result with we low", result, 32'h00000000);
    @(posedge clk);
    #1 check("R9 hold when we low", {28'd0, ge_flags}, 32'h5);

    // R8 with flags all zero picks op_b; load zeros first via unsigned add
    @(negedge clk);
    flag_we = 1'b1; opcode = 4'b0000; op_a = 32'h01010101; op_b = 32'h01010101;
    @(posedge clk);
    #1 check("R9 load zeros", {28'd0, ge_flags}, 32'h0);
    @(negedge clk);
    opcode = 4'b1000; op_a = 32'hDEADBEEF; op_b = 32'hCAFEF00D;
    #1 check("R8 select all b", result, 32'hCAFEF00D);

    // R10: asynchronous reset clears loaded flags
    @(negedge clk);
    opcode = 4'b0011; op_a = 32'h01010101; op_b = 32'h00000000;
    @(posedge clk);
    #1 check("R5 load ones", {28'd0, ge_flags}, 32'hF);
    #3 rst_n = 1'b0;
    #1 check("R10 async clear", {28'd0, ge_flags}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    flag_we = 1'b0;
    repeat (3) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule